// File: doc/BRIEF.md
# Clock Reference Selection and Loop Mode Controller

This block is the decision core of a line-card clock synchronizer. Three candidate timing references each present a qualification flag and a two-bit frequency class. The controller picks one of them as the active reference, either automatically or by a forced index. In automatic operation the choice goes by a programmable per-reference priority and may be revertive or non-revertive. It also runs the loop mode machine (free-run, locked, holdover), picks a loop bandwidth code, and emits a one-cycle hitless-switch request whenever the active reference changes.

The phase detector, loop filter and frequency measurement sit outside this block. The loop supplies a lock-detect level and the measurement logic supplies the frequency class of each reference. Configuration comes in on a single-cycle write port (`cfg_we`, `cfg_addr`, `cfg_wdata`) with no back-pressure: every write is accepted on the clock edge where `cfg_we` is high. All other pins are plain control and status levels.

Top module: `refsel_core`

## Requirements
- R1: Writes take effect from the edge after they are captured. The register map is:
  - address 0, control: bit 0 forces manual mode, bit 1 enables revertive switching, bit 2 enables the hitless strobe, bits 4:3 select bandwidth (0 = 14 Hz, 1 = 28 Hz, 2 or 3 = wideband).
  - address 1: manual index, bits 1:0.
  - addresses 2, 3, 4: priority of reference 0, 1, 2, bits 3:0.
  - address 5: lock qualification count, bits 7:0, where 0 acts as 1.
  - All other addresses are ignored.
  - Reset values: control 0, manual index 0, priorities 0/1/2, count 4.
- R2: In automatic mode only a qualified reference whose priority is not 15 may become active. The lowest priority value wins, and a tie goes to the lower index. `act_valid` is low when no reference is eligible.
- R3: With revertive switching on, a better eligible reference replaces the active one on the next edge.
- R4: With revertive switching off, the active reference is kept until it loses qualification or is given priority 15.
- R5: In manual mode the active reference is the manual index whenever that reference is qualified, regardless of its priority. If it is not qualified, or the index is 3, `act_valid` is low and no other reference is chosen.
- R6: After reset the mode is free-run (`loop_mode` = 0). The mode becomes locked (`loop_mode` = 1) once `lock_det` has been high for the programmed count of consecutive edges with a valid active reference. A low `lock_det` or a missing reference restarts the count.
- R7: The mode moves from locked to holdover (`loop_mode` = 2) one edge after `act_valid` falls. Holdover returns to locked only through the same lock qualification. Free-run never enters holdover.
- R8: `hitless_stb` is high for exactly the cycle in which `act_ref` changes from one valid reference to a different valid reference, and only when the hitless enable is set.
- R9: `bw_code` is 0 = 14 Hz, 1 = 28 Hz, 2 = 56 Hz, 3 = 890 Hz. In wideband mode it follows the class of the active reference: class 0 (2 kHz) gives 0, class 1 (8 to below 64 kHz) gives 2, and classes 2 and 3 (64 kHz and above) give 3. With no active reference it gives 0.
- R10: `locked` is high exactly in the locked mode and `holdover` exactly in holdover. They are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| ref_qual | input | 3 | Qualification flag per reference |
| ref_fclass | input | 6 | Two-bit frequency class per reference, reference n at bits 2n+1:2n |
| lock_det | input | 1 | Lock indication from the loop |
| act_ref | output | 2 | Active reference index |
| act_valid | output | 1 | An active reference is selected |
| loop_mode | output | 2 | 0 free-run, 1 locked, 2 holdover |
| bw_code | output | 2 | Loop bandwidth code |
| locked | output | 1 | Locked status |
| holdover | output | 1 | Holdover status |
| hitless_stb | output | 1 | One-cycle hitless switch request |

## Verification
The assertions check several properties on every cycle:
- an active reference was qualified on the edge that chose it;
- the strobe coincides with a real change between two valid references;
- the two status pins exclude each other;
- holdover is entered only from locked;
- lock is gained only with a reference present and `lock_det` high.

Other behaviours depend on the configuration history and only the bench scenarios can show them:
- priority order and tie-breaking;
- exclusion by priority 15;
- revertive versus non-revertive holding;
- the refusal of manual mode to fall back to another reference;
- the exact lock count, including a count of zero;
- the wideband bandwidth mapping.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
  localparam int NREF     = 3;
  localparam int IDX_W    = 2;
  localparam int PRIO_W   = 4;
  localparam int LOCKN_W  = 8;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int CLASS_W  = 2;
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAN   = 3'd1;
  localparam int                A_PRIO0 = 2;
  localparam logic [ADDR_W-1:0] A_LOCKN = 3'd5;

  typedef enum logic [1:0] {M_FREE = 2'd0, M_LOCK = 2'd1, M_HOLD = 2'd2} mode_e;

  localparam logic [1:0] BW_14  = 2'd0;
  localparam logic [1:0] BW_28  = 2'd1;
  localparam logic [1:0] BW_56  = 2'd2;
  localparam logic [1:0] BW_890 = 2'd3;

  typedef struct packed {
    logic                         manual;
    logic                         revert;
    logic                         hitless;
    logic [1:0]                   bw_sel;
    logic [IDX_W-1:0]             man_idx;
    logic [NREF-1:0][PRIO_W-1:0]  prio;
    logic [LOCKN_W-1:0]           lock_n;
  } cfg_t;
endpackage

// File: rtl/refsel_regs.sv
`timescale 1ns/1ps
module refsel_regs
  import refsel_pkg::*;
#(
  parameter int LOCK_DEF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.manual  <= 1'b0;
      cfg.revert  <= 1'b0;
      cfg.hitless <= 1'b0;
      cfg.bw_sel  <= 2'd0;
      cfg.man_idx <= '0;
      for (int i = 0; i < NREF; i++) cfg.prio[i] <= PRIO_W'(i);
      cfg.lock_n  <= LOCKN_W'(LOCK_DEF);
    end else if (we) begin
      if (addr == A_CTRL) begin
        cfg.manual  <= wdata[0];
        cfg.revert  <= wdata[1];
        cfg.hitless <= wdata[2];
        cfg.bw_sel  <= wdata[4:3];
      end
      if (addr == A_MAN) cfg.man_idx <= wdata[IDX_W-1:0];
      for (int i = 0; i < NREF; i++)
        if (addr == ADDR_W'(A_PRIO0 + i)) cfg.prio[i] <= wdata[PRIO_W-1:0];
      if (addr == A_LOCKN) cfg.lock_n <= wdata[LOCKN_W-1:0];
    end
  end
endmodule

// File: rtl/refsel_pick.sv
`timescale 1ns/1ps
module refsel_pick
  import refsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [NREF-1:0]  qual,
  output logic [IDX_W-1:0] act_idx,
  output logic             act_ok,
  output logic             hit_stb
);
  logic [NREF-1:0]   elig;
  logic              best_ok, cur_elig, man_ok;
  logic [IDX_W-1:0]  best_idx, nxt_idx;
  logic [PRIO_W-1:0] best_pri;
  logic              nxt_ok;

  for (genvar g = 0; g < NREF; g++) begin : g_elig
    assign elig[g] = qual[g] && (cfg.prio[g] != PRIO_OFF);
  end

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_pri = '1;
    for (int i = 0; i < NREF; i++)
      if (elig[i] && (!best_ok || cfg.prio[i] < best_pri)) begin
        best_ok  = 1'b1;
        best_idx = IDX_W'(i);
        best_pri = cfg.prio[i];
      end
  end

  always_comb begin
    cur_elig = 1'b0;
    man_ok   = 1'b0;
    for (int i = 0; i < NREF; i++) begin
      if (act_idx == IDX_W'(i))     cur_elig = elig[i];
      if (cfg.man_idx == IDX_W'(i)) man_ok   = qual[i];
    end
  end

  always_comb begin
    nxt_idx = act_idx;
    nxt_ok  = act_ok;
    if (cfg.manual) begin
      nxt_idx = cfg.man_idx;
      nxt_ok  = man_ok;
    end else if (cfg.revert || !(act_ok && cur_elig)) begin
      nxt_ok  = best_ok;
      if (best_ok) nxt_idx = best_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idx <= '0;
      act_ok  <= 1'b0;
      hit_stb <= 1'b0;
    end else begin
      act_idx <= nxt_idx;
      act_ok  <= nxt_ok;
      hit_stb <= cfg.hitless && act_ok && nxt_ok && (nxt_idx != act_idx);
    end
  end
endmodule

// File: rtl/refsel_mode.sv
`timescale 1ns/1ps
module refsel_mode
  import refsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_ok,
  input  logic               lock_det,
  input  logic [LOCKN_W-1:0] lock_n,
  output mode_e              mode
);
  logic [LOCKN_W-1:0] cnt;
  logic [LOCKN_W:0]   need;
  logic               qual_done;

  assign need      = (lock_n == '0) ? (LOCKN_W+1)'(1) : {1'b0, lock_n};
  assign qual_done = ({1'b0, cnt} + (LOCKN_W+1)'(1)) >= need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_FREE;
      cnt  <= '0;
    end else if (mode == M_LOCK) begin
      cnt <= '0;
      if (!ref_ok) mode <= M_HOLD;
    end else if (ref_ok && lock_det) begin
      if (qual_done) begin
        mode <= M_LOCK;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/refsel_bw.sv
`timescale 1ns/1ps
module refsel_bw
  import refsel_pkg::*;
(
  input  logic [1:0]              bw_sel,
  input  logic [IDX_W-1:0]        act_idx,
  input  logic                    act_ok,
  input  logic [NREF*CLASS_W-1:0] fclass,
  output logic [1:0]              bw_code
);
  logic [CLASS_W-1:0] cls;

  always_comb begin
    cls = '0;
    for (int i = 0; i < NREF; i++)
      if (act_idx == IDX_W'(i)) cls = fclass[i*CLASS_W +: CLASS_W];
  end

  always_comb begin
    unique case (bw_sel)
      2'd0: bw_code = BW_14;
      2'd1: bw_code = BW_28;
      default: begin
        if (!act_ok)           bw_code = BW_14;
        else if (cls == 2'd0)  bw_code = BW_14;
        else if (cls == 2'd1)  bw_code = BW_56;
        else                   bw_code = BW_890;
      end
    endcase
  end
endmodule

// File: rtl/refsel_core.sv
`timescale 1ns/1ps
module refsel_core
  import refsel_pkg::*;
#(
  parameter int LOCK_DEF = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [NREF-1:0]         ref_qual,
  input  logic [NREF*CLASS_W-1:0] ref_fclass,
  input  logic                    lock_det,
  output logic [IDX_W-1:0]        act_ref,
  output logic                    act_valid,
  output logic [1:0]              loop_mode,
  output logic [1:0]              bw_code,
  output logic                    locked,
  output logic                    holdover,
  output logic                    hitless_stb
);
  cfg_t  cfg;
  mode_e mode;

  refsel_regs #(.LOCK_DEF(LOCK_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  refsel_pick u_pick (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .qual(ref_qual),
    .act_idx(act_ref), .act_ok(act_valid), .hit_stb(hitless_stb)
  );

  refsel_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ref_ok(act_valid), .lock_det(lock_det),
    .lock_n(cfg.lock_n), .mode(mode)
  );

  refsel_bw u_bw (
    .bw_sel(cfg.bw_sel), .act_idx(act_ref), .act_ok(act_valid),
    .fclass(ref_fclass), .bw_code(bw_code)
  );

  assign loop_mode = mode;
  assign locked    = (mode == M_LOCK);
  assign holdover  = (mode == M_HOLD);
endmodule

// File: rtl/refsel_core_chk.sv
`timescale 1ns/1ps
module refsel_core_chk
  import refsel_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [ADDR_W-1:0]       cfg_addr,
  input logic [DATA_W-1:0]       cfg_wdata,
  input logic [NREF-1:0]         ref_qual,
  input logic [NREF*CLASS_W-1:0] ref_fclass,
  input logic                    lock_det,
  input logic [IDX_W-1:0]        act_ref,
  input logic                    act_valid,
  input logic [1:0]              loop_mode,
  input logic [1:0]              bw_code,
  input logic                    locked,
  input logic                    holdover,
  input logic                    hitless_stb
);
  // R2
  act_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> ((($past(ref_qual)) >> act_ref) & 3'b001) != 3'b000);

  // R8
  stb_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hitless_stb |-> (act_valid && $past(act_valid) && act_ref != $past(act_ref)));

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && holdover));

  // R7
  hold_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> $past(locked));

  // R6
  lock_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(act_valid) && $past(lock_det)));
endmodule

bind refsel_core refsel_core_chk u_chk (.*);

// File: tb/refsel_core_test.sv
`timescale 1ns/1ps
module refsel_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] ref_qual = '0;
  logic [5:0] ref_fclass = '0;
  logic       lock_det = 1'b0;
  logic [1:0] act_ref, loop_mode, bw_code;
  logic       act_valid, locked, holdover, hitless_stb;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  refsel_core uut (.*);

  // behavioural reference model
  int m_man, m_rev, m_hit, m_bw, m_midx, m_lockn;
  int m_prio[3];
  int m_valid, m_ref, m_mode, m_cnt, m_stb;

  task automatic model_reset();
    m_man = 0; m_rev = 0; m_hit = 0; m_bw = 0; m_midx = 0; m_lockn = 4;
    m_prio[0] = 0; m_prio[1] = 1; m_prio[2] = 2;
    m_valid = 0; m_ref = 0; m_mode = 0; m_cnt = 0; m_stb = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int best, bp, nv, nr, need, cur_ok;
      best = -1; bp = 99;
      for (int i = 0; i < 3; i++)
        if (ref_qual[i] && m_prio[i] != 15 && m_prio[i] < bp) begin best = i; bp = m_prio[i]; end
      nv = m_valid; nr = m_ref;
      if (m_man != 0) begin
        nr = m_midx;
        nv = (m_midx < 3) ? int'(ref_qual[m_midx]) : 0;
      end else begin
        cur_ok = m_valid && ref_qual[m_ref] && m_prio[m_ref] != 15;
        if (m_rev != 0 || !cur_ok) begin
          nv = (best >= 0);
          if (best >= 0) nr = best;
        end
      end
      m_stb = (m_hit != 0 && m_valid != 0 && nv != 0 && nr != m_ref);
      need = (m_lockn == 0) ? 1 : m_lockn;
      if (m_mode == 1) begin
        m_cnt = 0;
        if (m_valid == 0) m_mode = 2;
      end else if (m_valid != 0 && lock_det) begin
        m_cnt++;
        if (m_cnt >= need) begin m_mode = 1; m_cnt = 0; end
      end else m_cnt = 0;
      m_valid = nv; m_ref = nr;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_man = cfg_wdata[0]; m_rev = cfg_wdata[1]; m_hit = cfg_wdata[2]; m_bw = cfg_wdata[4:3]; end
          3'd1: m_midx = cfg_wdata[1:0];
          3'd2, 3'd3, 3'd4: m_prio[cfg_addr - 2] = cfg_wdata[3:0];
          3'd5: m_lockn = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_bw();
    int c;
    if (m_bw == 0) return 0;
    if (m_bw == 1) return 1;
    if (m_valid == 0) return 0;
    c = (ref_fclass >> (2 * m_ref)) & 3;
    if (c == 0) return 0;
    if (c == 1) return 2;
    return 3;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      vectors++;
      cmp("R2", "act_valid", act_valid, m_valid);
      if (m_valid != 0) cmp("R3", "act_ref", act_ref, m_ref);
      cmp("R6", "loop_mode", loop_mode, m_mode);
      cmp("R10", "locked", locked, m_mode == 1);
      cmp("R10", "holdover", holdover, m_mode == 2);
      cmp("R8", "hitless_stb", hitless_stb, m_stb);
      cmp("R9", "bw_code", bw_code, exp_bw());
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    cmp(req, what, act, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 / R6: reset state is free-run with no reference
    chk("R6", "reset mode", loop_mode, 0);
    chk("R1", "reset act_valid", act_valid, 0);

    // R6: lock after the default count of 4
    ref_qual = 3'b111; lock_det = 1'b1;
    tick(8);
    chk("R6", "locked", locked, 1);
    chk("R2", "priority 0 wins", act_ref, 0);

    // R4: non-revertive holds the fallback
    ref_qual = 3'b110; tick(3);
    chk("R4", "fallback", act_ref, 1);
    ref_qual = 3'b111; tick(3);
    chk("R4", "no revert", act_ref, 1);

    // R3 / R8: revertive with hitless strobe
    wr(0, 8'b0_0110); tick(3);
    chk("R3", "reverted", act_ref, 0);

    // R2: exclusion and tie-break
    wr(2, 15); tick(3);
    chk("R2", "excluded", act_ref, 1);
    wr(4, 1); tick(2);
    chk("R2", "tie lower index", act_ref, 1);
    wr(3, 2); tick(3);
    chk("R2", "better priority", act_ref, 2);

    // R7: holdover and reacquisition
    ref_qual = 3'b000; tick(3);
    chk("R7", "holdover", holdover, 1);
    lock_det = 1'b0; ref_qual = 3'b111; tick(6);
    chk("R7", "still holdover", holdover, 1);
    lock_det = 1'b1; tick(6);
    chk("R7", "relocked", locked, 1);

    // R9: wideband mapping on active reference 2
    wr(0, 8'b1_0110); ref_fclass = 6'b10_01_00; tick(2);
    chk("R9", "890", bw_code, 3);
    ref_fclass = 6'b01_01_00; tick(2);
    chk("R9", "56", bw_code, 2);
    ref_fclass = 6'b00_11_11; tick(2);
    chk("R9", "14", bw_code, 0);
    wr(0, 8'b0_1110); tick(2);
    chk("R9", "28", bw_code, 1);

    // R5: manual selection without fallback
    wr(0, 8'b0_1111); tick(3);
    chk("R5", "manual ref0", act_ref, 0);
    wr(1, 2); tick(3);
    chk("R5", "manual ref2", act_ref, 2);
    ref_qual = 3'b011; tick(4);
    chk("R5", "no fallback", act_valid, 0);
    chk("R7", "manual holdover", holdover, 1);
    wr(1, 3); tick(3);
    chk("R5", "index 3", act_valid, 0);

    // R1: lock count 0 behaves as 1; unused address ignored
    wr(7, 8'hFF);
    wr(0, 8'b0_0000); wr(5, 0); tick(3);
    chk("R1", "count zero", locked, 1);

    // mixed traffic checked against the model every cycle
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      ref_qual   = 3'($urandom_range(0, 7));
      lock_det   = ($urandom_range(0, 3) != 0);
      ref_fclass = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 3'($urandom_range(0, 7));
        cfg_wdata = 8'($urandom_range(0, 31));
      end else cfg_we = 1'b0;
    end
    @(negedge clk); cfg_we = 1'b0;
    tick(4);
    finish_run();
  end
endmodule